// File: doc/BRIEF.md
# Indexed Clock Register Port

This block gives a host processor access to a real-time clock's register space through two byte-wide ports. The host first writes a location number to the index port. It then reads or writes the chosen location through the data port. The index stays latched, so repeated data accesses reach the same location.

The space has 64 locations:
- Indexes 0 to 9 hold the time and alarm bytes.
- Indexes 10 to 13 are the four control registers.
- Indexes 14 to 63 are general-purpose storage.

The first control register carries the rate and divider selects and a read-only busy bit. The second carries mode bits and the three interrupt enables. The third collects sticky event flags and a summary request bit. The fourth reports that time and storage are valid.

The calendar counter and the rate divider sit outside this block. They supply event pulses and the busy level, and they receive the mode and select fields.

Top module: `rtcRegIf`

## Requirements
- R1: A write with `portSel`=0 latches the low 6 bits of `wrData` as the index. The index stays unchanged until the next such write. A read with `portSel`=0 returns 0x00.
- R2: Indexes 0–9 and 14–63 read back the last byte written to them through the data port.
- R3: At index 10, bits 6:0 are read/write. Bit 3:0 drives `rateSel` and bits 6:4 drive `divSel`. Bit 7 reads the `updateBusy` input and ignores writes.
- R4: At index 11, all 8 bits are read/write and drive `modeBits`. Bit 4 enables update-end, bit 5 enables alarm and bit 6 enables periodic.
- R5: Index 12 holds sticky flags: bit 4 for update-end, bit 5 for alarm and bit 6 for periodic. A one-cycle pulse on the matching event input sets the flag whatever the enables are. Bits 3:0 read 0.
- R6: Bit 7 of index 12 is 1 while any flag is set together with its enable in index 11, and `irq` equals that bit.
- R7: A data-port read of index 12 returns the current contents and clears all flags at the end of that cycle. An event pulse in the same cycle leaves its flag set.
- R8: Data-port writes to indexes 12 and 13 change nothing.
- R9: Index 13 always reads 0x80.
- R10: After reset:
  - the index is 0;
  - indexes 10 and 11 hold 0, apart from the busy bit;
  - all flags are clear;
  - storage reads 0;
  - `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| portSel | input | 1 | 0 selects the index port, 1 selects the data port |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte, combinational, 0 when not reading the data port |
| updateBusy | input | 1 | Busy level from the calendar counter |
| updateEndEvt | input | 1 | Update-end event pulse |
| alarmEvt | input | 1 | Alarm match event pulse |
| periodicEvt | input | 1 | Periodic tick event pulse |
| modeBits | output | 8 | Contents of index 11 |
| rateSel | output | 4 | Periodic rate select (index 10 bits 3:0) |
| divSel | output | 3 | Divider select (index 10 bits 6:4) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A read of the flag register and a new event pulse can land in the same cycle, so the clear and the set compete for the same flag. The bench arranges this by asserting `rdEn` at index 12 together with `periodicEvt` while only the alarm flag is set. The read must return the old value with the alarm flag and no periodic bit. A second read must then show the periodic flag alone, and `irq` must stay low because periodic is not enabled.

// File: rtl/rtcRegPkg.sv
package rtcRegPkg;
  localparam int REG_W   = 8;
  localparam int TOD_CNT = 10;
  localparam int IDX_A   = TOD_CNT;
  localparam int IDX_B   = TOD_CNT + 1;
  localparam int IDX_C   = TOD_CNT + 2;
  localparam int IDX_D   = TOD_CNT + 3;
  localparam int GP_BASE = TOD_CNT + 4;
  localparam int EVT_N   = 3;
  localparam int FLAG_LSB = 4;
  localparam logic [REG_W-1:0] VALID_WORD = 8'h80;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MEM, SEL_A, SEL_B, SEL_C, SEL_D
  } rdSel_e;

  typedef struct packed {
    logic idxWr;
    logic memWr;
    logic aWr;
    logic bWr;
    logic flagClr;
  } hostStrobe_t;
endpackage

// File: rtl/rtcRegCtrl.sv
module rtcRegCtrl
  import rtcRegPkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              portSel,
  input  logic [IDX_W-1:0]  curIdx,
  output hostStrobe_t       strobe,
  output rdSel_e            rdSel
);
  logic isA, isB, isC, isD, isMem, dataWr, dataRd;

  always_comb begin
    isA    = (curIdx == IDX_W'(IDX_A));
    isB    = (curIdx == IDX_W'(IDX_B));
    isC    = (curIdx == IDX_W'(IDX_C));
    isD    = (curIdx == IDX_W'(IDX_D));
    isMem  = !(isA || isB || isC || isD);
    dataWr = wrEn && portSel;
    dataRd = rdEn && portSel && !wrEn;
  end

  always_comb begin
    strobe.idxWr   = wrEn && !portSel;
    strobe.memWr   = dataWr && isMem;
    strobe.aWr     = dataWr && isA;
    strobe.bWr     = dataWr && isB;
    strobe.flagClr = dataRd && isC;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (dataRd) begin
      if (isA)      rdSel = SEL_A;
      else if (isB) rdSel = SEL_B;
      else if (isC) rdSel = SEL_C;
      else if (isD) rdSel = SEL_D;
      else          rdSel = SEL_MEM;
    end
  end

  // R8: at most one write target, never the flag or valid register
  always_comb begin
    a_r8_one_target: assert ($onehot0({strobe.memWr, strobe.aWr, strobe.bWr, strobe.idxWr}));
  end
endmodule

// File: rtl/rtcFlagUnit.sv
module rtcFlagUnit
  import rtcRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_N-1:0] evt,
  input  logic [EVT_N-1:0] enable,
  input  logic             clr,
  output logic [EVT_N-1:0] flags,
  output logic             summary
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (clr ? '0 : flags) | evt;
  end

  always_comb summary = |(flags & enable);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && evt == '0) |=> $stable(flags));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clr && evt == '0) |=> (flags == '0));
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/rtcRegData.sv
module rtcRegData
  import rtcRegPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  rdSel_e            rdSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              updateBusy,
  input  logic [EVT_N-1:0]  flags,
  input  logic              summary,
  output logic [IDX_W-1:0]  curIdx,
  output logic [REG_W-1:0]  regB,
  output logic [REG_W-2:0]  regALow,
  output logic [REG_W-1:0]  rdData
);
  logic [REG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curIdx <= '0;
    else if (strobe.idxWr) curIdx <= wrData[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regALow <= '0;
      regB    <= '0;
    end else begin
      if (strobe.aWr) regALow <= wrData[REG_W-2:0];
      if (strobe.bWr) regB    <= wrData;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[g] <= '0;
      else if (strobe.memWr && curIdx == IDX_W'(g)) mem[g] <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_MEM: rdData = mem[curIdx];
      SEL_A:   rdData = {updateBusy, regALow};
      SEL_B:   rdData = regB;
      SEL_C:   rdData = {summary, flags, {FLAG_LSB{1'b0}}};
      SEL_D:   rdData = VALID_WORD;
      default: rdData = '0;
    endcase
  end

  a_r1_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.idxWr |=> $stable(curIdx));
  a_r1_idx_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idxWr |=> (curIdx == $past(wrData[IDX_W-1:0])));
  a_r3_busy_bit: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_A) |-> (rdData[REG_W-1] == updateBusy));
  a_r4_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bWr |=> $stable(regB));
endmodule

// File: rtl/rtcRegIf.sv
module rtcRegIf
  import rtcRegPkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             portSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             updateBusy,
  input  logic             updateEndEvt,
  input  logic             alarmEvt,
  input  logic             periodicEvt,
  output logic [7:0]       modeBits,
  output logic [3:0]       rateSel,
  output logic [2:0]       divSel,
  output logic             irq
);
  localparam int IDX_W = $clog2(DEPTH);

  hostStrobe_t      strobe;
  rdSel_e           rdSel;
  logic [IDX_W-1:0] curIdx;
  logic [REG_W-1:0] regB;
  logic [REG_W-2:0] regALow;
  logic [EVT_N-1:0] flags;
  logic             summary;

  rtcRegCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel), .curIdx(curIdx),
    .strobe(strobe), .rdSel(rdSel)
  );

  rtcRegData #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .wrData(wrData),
    .updateBusy(updateBusy), .flags(flags), .summary(summary),
    .curIdx(curIdx), .regB(regB), .regALow(regALow), .rdData(rdData)
  );

  rtcFlagUnit u_flags (
    .clk(clk), .rstN(rstN),
    .evt({periodicEvt, alarmEvt, updateEndEvt}),
    .enable(regB[FLAG_LSB+EVT_N-1:FLAG_LSB]),
    .clr(strobe.flagClr), .flags(flags), .summary(summary)
  );

  always_comb begin
    modeBits = regB;
    rateSel  = regALow[3:0];
    divSel   = regALow[6:4];
    irq      = summary;
  end

  // R6: a request cannot appear without a pending flag and its enable
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0 && modeBits[6:4] != 3'b000));
endmodule

// File: tb/rtcRegIf_tb.sv
module rtcRegIf_tb;
  logic clk = 0, rstN = 0;
  logic wrEn = 0, rdEn = 0, portSel = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData, modeBits;
  logic updateBusy = 0, updateEndEvt = 0, alarmEvt = 0, periodicEvt = 0;
  logic [3:0] rateSel;
  logic [2:0] divSel;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtcRegIf u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .updateBusy(updateBusy),
    .updateEndEvt(updateEndEvt), .alarmEvt(alarmEvt), .periodicEvt(periodicEvt),
    .modeBits(modeBits), .rateSel(rateSel), .divSel(divSel), .irq(irq)
  );

  // {req[3:0], kind[1:0], val[7:0], exp[7:0]}; kind 0 index, 1 write, 2 read
  localparam int NV = 26;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2,2'd0,8'h00,8'h00}, {4'd2,2'd1,8'h59,8'h00},
    {4'd2,2'd0,8'h09,8'h00}, {4'd2,2'd1,8'h99,8'h00},
    {4'd2,2'd0,8'h0E,8'h00}, {4'd2,2'd1,8'hA5,8'h00},
    {4'd2,2'd0,8'h3F,8'h00}, {4'd2,2'd1,8'h3C,8'h00},
    {4'd2,2'd0,8'h00,8'h00}, {4'd2,2'd2,8'h00,8'h59},
    {4'd2,2'd0,8'h09,8'h00}, {4'd2,2'd2,8'h00,8'h99},
    {4'd2,2'd0,8'h0E,8'h00}, {4'd2,2'd2,8'h00,8'hA5},
    {4'd2,2'd0,8'h3F,8'h00}, {4'd2,2'd2,8'h00,8'h3C},
    {4'd4,2'd0,8'h0B,8'h00}, {4'd4,2'd1,8'h06,8'h00},
    {4'd4,2'd2,8'h00,8'h06}, {4'd1,2'd2,8'h00,8'h06},
    {4'd3,2'd0,8'h0A,8'h00}, {4'd3,2'd1,8'hA6,8'h00},
    {4'd3,2'd2,8'h00,8'h26}, {4'd8,2'd0,8'h0D,8'h00},
    {4'd8,2'd1,8'h55,8'h00}, {4'd9,2'd2,8'h00,8'h80}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic setIdx(input logic [7:0] v);
    @(negedge clk); wrEn = 1; portSel = 0; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic writeData(input logic [7:0] v);
    @(negedge clk); wrEn = 1; portSel = 1; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic readData(input string req, input logic [7:0] exp);
    @(negedge clk); rdEn = 1; portSel = 1;
    #5 check(req, rdData, exp);
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk); {periodicEvt, alarmEvt, updateEndEvt} = m;
    @(negedge clk); {periodicEvt, alarmEvt, updateEndEvt} = 3'b000;
  endtask

  task automatic checkIrq(input string req, input logic exp);
    @(negedge clk); #5 check(req, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R10: reset state
    readData("R10 index0 storage", 8'h00);
    checkIrq("R10 irq", 1'b0);
    check("R10 modeBits", modeBits, 8'h00);
    setIdx(8'h0A); readData("R10 regA", 8'h00);
    setIdx(8'h0C); readData("R10 flags", 8'h00);

    // table walk: R1 R2 R3 R4 R8 R9
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][21:18], i);
      case (VEC[i][17:16])
        2'd0: setIdx(VEC[i][15:8]);
        2'd1: writeData(VEC[i][15:8]);
        default: readData(tag, VEC[i][7:0]);
      endcase
    end

    // R3 R4: select and mode outputs
    check("R4 modeBits", modeBits, 8'h06);
    check("R3 rateSel", {4'd0, rateSel}, 8'h06);
    check("R3 divSel", {5'd0, divSel}, 8'h02);

    // R5: flag sets without enable, R6 no request
    setIdx(8'h0B); writeData(8'h00);
    pulse(3'b010);
    checkIrq("R6 disabled no irq", 1'b0);
    setIdx(8'h0C);
    readData("R5 alarm flag", 8'h20);
    readData("R7 cleared", 8'h00);
    // R8: write to flags ignored
    writeData(8'hF0);
    readData("R8 flag write ignored", 8'h00);

    // R6: enabled request
    setIdx(8'h0B); writeData(8'h20);
    pulse(3'b010);
    checkIrq("R6 irq high", 1'b1);
    setIdx(8'h0C);
    readData("R6 summary bit", 8'hA0);
    checkIrq("R7 irq after clear", 1'b0);

    // R7: collision of clear with new periodic event
    pulse(3'b010);
    @(negedge clk); rdEn = 1; portSel = 1; periodicEvt = 1;
    #5 check("R7 collision read", rdData, 8'hA0);
    @(negedge clk); rdEn = 0; periodicEvt = 0;
    checkIrq("R6 periodic not enabled", 1'b0);
    readData("R7 event survives", 8'h40);

    // R5: update-end flag
    pulse(3'b001);
    readData("R5 update flag", 8'h10);

    // R3: busy bit follows input
    updateBusy = 1;
    setIdx(8'h0A);
    readData("R3 busy bit", 8'hA6);
    updateBusy = 0;

    // R1: index port reads zero, index masking
    @(negedge clk); rdEn = 1; portSel = 0;
    #5 check("R1 index port read", rdData, 8'h00);
    @(negedge clk); rdEn = 0;
    setIdx(8'h4E);
    readData("R1 masked index", 8'hA5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule